// File: doc/BRIEF.md
# Accumulator Datapath with Paired Shifter

This unit is the arithmetic core of a small microcoded machine. It holds a 16-bit accumulator and a 16-bit helper register. Each clock cycle it takes one operation code and an operand from the shared data bus. The operations are: hold, clear, load, load-complement, single-register shifts and a rotate of the accumulator, and shifts of the accumulator and helper joined into one 32-bit word. In that joined word the accumulator is the upper half. Every operation finishes in the cycle it is presented, and results show on the register outputs after that clock edge.

Three flags are kept. The zero flag does not test the accumulator against zero. It reports whether the new accumulator value equals the bus operand seen in the same cycle. The negative flag mirrors the accumulator sign bit. The carry flag holds the bit that was last pushed out by a shift or rotate. A separate strobe loads the helper register straight from the bus. A status output reports the cycles in which a shift operation occupies the bus.

Top module: `acc_shift_unit`

## Requirements
- R1: A synchronous active-high reset clears the accumulator, the helper register and the zero, negative and carry flags on the next rising clock edge.
- R2: Code 0 (hold) and the unused codes 10 to 15 change neither register nor any flag.
- R3: Code 1 (clear) sets the accumulator to 0 and clears carry and negative; zero is set only if the bus operand is 0.
- R4: Code 2 loads the accumulator with the bus operand and code 3 loads its bitwise complement; both clear carry.
- R5: Code 4 shifts the accumulator left by one with a 0 entering bit 0; carry takes the old bit 15.
- R6: Code 5 shifts the accumulator right by one with a 0 entering bit 15; carry takes the old bit 0.
- R7: Code 6 shifts the accumulator right by one with the old bit 15 kept in bit 15; carry takes the old bit 0.
- R8: Code 7 rotates the accumulator left by one, so the old bit 15 enters bit 0 and is also copied into carry.
- R9: Code 8 shifts the 32-bit word {accumulator, helper} left by one with a 0 entering helper bit 0; carry takes the old accumulator bit 15.
- R10: Code 9 shifts the 32-bit word {accumulator, helper} right by one, keeping the accumulator sign bit; the old accumulator bit 0 enters helper bit 15, and carry takes the old helper bit 0.
- R11: Codes 1 to 9 set zero when the new accumulator equals the bus operand of that cycle and set negative to bit 15 of the new accumulator.
- R12: The helper-load strobe writes the bus operand into the helper register, except when codes 8 or 9 are presented, which take precedence.
- R13: The bus-busy output is high during exactly the cycles in which codes 4 to 9 are presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 4 | Operation selected this cycle |
| bus_in | input | 16 | Shared bus operand |
| hr_load | input | 1 | Write helper register from the bus |
| acc_q | output | 16 | Accumulator register |
| hlp_q | output | 16 | Helper register |
| flag_z | output | 1 | Accumulator-equals-bus flag |
| flag_n | output | 1 | Accumulator sign flag |
| flag_c | output | 1 | Last shifted-out bit |
| bus_busy | output | 1 | A shift is using the bus this cycle |

## Verification
The two registers and the flags are all outputs, so a wrong accumulator, helper or flag value shows at the ports one clock edge after the operation that caused it. A fault in the boundary bits of a shift takes longer to show when the bit is only copied into carry or moved into the other register. It shows when carry is read or when the moved bit reaches the accumulator's bit 15. A chain of shifts on varied values therefore exposes the fault within a few operations. Bus-busy is combinational from the operation code and can be checked before the edge.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_NOP = 4'd0,
    OP_CLR = 4'd1,
    OP_MOV = 4'd2,
    OP_MVN = 4'd3,
    OP_LSL = 4'd4,
    OP_LSR = 4'd5,
    OP_ASR = 4'd6,
    OP_ROL = 4'd7,
    OP_PSL = 4'd8,
    OP_PSR = 4'd9
  } acc_op_e;

  typedef struct packed {
    logic upd_acc;
    logic is_shift;
    logic is_pair;
  } acc_dec_t;
endpackage

// File: rtl/acc_op_decode.sv
module acc_op_decode
  import acc_pkg::*;
(
  input  logic [OPW-1:0] op_code,
  output acc_dec_t       dec
);
  always_comb begin
    dec = '0;
    case (op_code)
      OP_CLR, OP_MOV, OP_MVN: dec.upd_acc = 1'b1;
      OP_LSL, OP_LSR, OP_ASR, OP_ROL: begin
        dec.upd_acc  = 1'b1;
        dec.is_shift = 1'b1;
      end
      OP_PSL, OP_PSR: begin
        dec.upd_acc  = 1'b1;
        dec.is_shift = 1'b1;
        dec.is_pair  = 1'b1;
      end
      default: dec = '0;
    endcase
  end
endmodule

// File: rtl/acc_shift_core.sv
module acc_shift_core
  import acc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [OPW-1:0] op_code,
  input  logic [W-1:0]   acc,
  input  logic [W-1:0]   hlp,
  input  logic [W-1:0]   bus_in,
  output logic [W-1:0]   acc_nxt,
  output logic [W-1:0]   hlp_nxt,
  output logic           carry_nxt,
  output logic           shl_evt,
  output logic           shr_evt
);
  localparam int PW = 2 * W;

  function automatic logic [W-1:0] shl1(input logic [W-1:0] v);
    return {v[W-2:0], 1'b0};
  endfunction

  function automatic logic [W-1:0] shr1(input logic [W-1:0] v, input logic fill);
    return {fill, v[W-1:1]};
  endfunction

  function automatic logic [W-1:0] rol1(input logic [W-1:0] v);
    return {v[W-2:0], v[W-1]};
  endfunction

  function automatic logic [PW-1:0] pair_shl(input logic [PW-1:0] v);
    return {v[PW-2:0], 1'b0};
  endfunction

  function automatic logic [PW-1:0] pair_asr(input logic [PW-1:0] v);
    return {v[PW-1], v[PW-1:1]};
  endfunction

  always_comb begin
    acc_nxt   = acc;
    hlp_nxt   = hlp;
    carry_nxt = 1'b0;
    shl_evt   = 1'b0;
    shr_evt   = 1'b0;
    case (op_code)
      OP_CLR: acc_nxt = '0;
      OP_MOV: acc_nxt = bus_in;
      OP_MVN: acc_nxt = ~bus_in;
      OP_LSL: begin
        acc_nxt   = shl1(acc);
        carry_nxt = acc[W-1];
        shl_evt   = 1'b1;
      end
      OP_LSR: begin
        acc_nxt   = shr1(acc, 1'b0);
        carry_nxt = acc[0];
        shr_evt   = 1'b1;
      end
      OP_ASR: begin
        acc_nxt   = shr1(acc, acc[W-1]);
        carry_nxt = acc[0];
        shr_evt   = 1'b1;
      end
      OP_ROL: begin
        acc_nxt   = rol1(acc);
        carry_nxt = acc[W-1];
        shl_evt   = 1'b1;
      end
      OP_PSL: begin
        {acc_nxt, hlp_nxt} = pair_shl({acc, hlp});
        carry_nxt = acc[W-1];
        shl_evt   = 1'b1;
      end
      OP_PSR: begin
        {acc_nxt, hlp_nxt} = pair_asr({acc, hlp});
        carry_nxt = hlp[0];
        shr_evt   = 1'b1;
      end
      default: begin
        acc_nxt = acc;
        hlp_nxt = hlp;
      end
    endcase
  end
endmodule

// File: rtl/acc_flag_unit.sv
module acc_flag_unit #(
  parameter int W = 16
) (
  input  logic [W-1:0] acc_nxt,
  input  logic [W-1:0] bus_in,
  output logic         z_nxt,
  output logic         n_nxt
);
  function automatic logic match(input logic [W-1:0] a, input logic [W-1:0] b);
    return (a == b);
  endfunction

  always_comb begin
    z_nxt = match(acc_nxt, bus_in);
    n_nxt = acc_nxt[W-1];
  end
endmodule

// File: rtl/acc_shift_unit.sv
module acc_shift_unit
  import acc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] op_code,
  input  logic [W-1:0]   bus_in,
  input  logic           hr_load,
  output logic [W-1:0]   acc_q,
  output logic [W-1:0]   hlp_q,
  output logic           flag_z,
  output logic           flag_n,
  output logic           flag_c,
  output logic           bus_busy
);
  acc_dec_t     dec;
  logic [W-1:0] acc_nxt;
  logic [W-1:0] hlp_nxt;
  logic         carry_nxt;
  logic         z_nxt;
  logic         n_nxt;
  logic         shl_evt;
  logic         shr_evt;

  acc_op_decode u_dec (
    .op_code (op_code),
    .dec     (dec)
  );

  acc_shift_core #(.W(W)) u_core (
    .op_code   (op_code),
    .acc       (acc_q),
    .hlp       (hlp_q),
    .bus_in    (bus_in),
    .acc_nxt   (acc_nxt),
    .hlp_nxt   (hlp_nxt),
    .carry_nxt (carry_nxt),
    .shl_evt   (shl_evt),
    .shr_evt   (shr_evt)
  );

  acc_flag_unit #(.W(W)) u_flag (
    .acc_nxt (acc_nxt),
    .bus_in  (bus_in),
    .z_nxt   (z_nxt),
    .n_nxt   (n_nxt)
  );

  assign bus_busy = dec.is_shift;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      hlp_q  <= '0;
      flag_z <= 1'b0;
      flag_n <= 1'b0;
      flag_c <= 1'b0;
    end else begin
      if (dec.upd_acc) begin
        acc_q  <= acc_nxt;
        flag_z <= z_nxt;
        flag_n <= n_nxt;
        flag_c <= carry_nxt;
      end
      if (dec.is_pair) begin
        hlp_q <= hlp_nxt;
      end else if (hr_load) begin
        hlp_q <= bus_in;
      end
    end
  end
endmodule

// File: rtl/acc_shift_chk.sv
module acc_shift_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [3:0]   op_code,
  input logic [W-1:0] bus_in,
  input logic         hr_load,
  input logic [W-1:0] acc_q,
  input logic [W-1:0] hlp_q,
  input logic         flag_z,
  input logic         flag_n,
  input logic         flag_c,
  input logic         shl_evt,
  input logic         shr_evt
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (acc_q == '0 && hlp_q == '0 && !flag_z && !flag_n && !flag_c)); // R1

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    ((op_code == 4'd0 || op_code > 4'd9) && !hr_load) |=>
      ($stable(acc_q) && $stable(hlp_q) && $stable(flag_z) && $stable(flag_n) && $stable(flag_c))); // R2

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (op_code == 4'd1) |=> (acc_q == '0 && !flag_c)); // R3

  AST_MVN_INVERT: assert property (@(posedge clk) disable iff (rst)
    (op_code == 4'd3) |=> (acc_q == ~$past(bus_in) && !flag_c)); // R4

  AST_ROL_CARRY: assert property (@(posedge clk) disable iff (rst)
    (op_code == 4'd7) |=> (flag_c == acc_q[0])); // R8

  AST_PAIR_LEFT_FILL: assert property (@(posedge clk) disable iff (rst)
    (op_code == 4'd8) |=> (hlp_q[0] == 1'b0)); // R9

  AST_PAIR_RIGHT_LINK: assert property (@(posedge clk) disable iff (rst)
    (op_code == 4'd9) |=> (hlp_q[W-1] == $past(acc_q[0]))); // R10

  AST_ZERO_IS_MATCH: assert property (@(posedge clk) disable iff (rst)
    (op_code inside {[4'd1:4'd9]}) |=> (flag_z == (acc_q == $past(bus_in)))); // R11

  AST_NEG_TRACKS_MSB: assert property (@(posedge clk) disable iff (rst)
    flag_n == acc_q[W-1]); // R11

  AST_HLP_LOAD: assert property (@(posedge clk) disable iff (rst)
    (hr_load && !(op_code inside {4'd8, 4'd9})) |=> (hlp_q == $past(bus_in))); // R12

  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (rst)
    $onehot0({shl_evt, shr_evt})); // R13
endmodule

bind acc_shift_unit acc_shift_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .op_code (op_code),
  .bus_in  (bus_in),
  .hr_load (hr_load),
  .acc_q   (acc_q),
  .hlp_q   (hlp_q),
  .flag_z  (flag_z),
  .flag_n  (flag_n),
  .flag_c  (flag_c),
  .shl_evt (shl_evt),
  .shr_evt (shr_evt)
);

// File: tb/tb_acc_shift_unit.sv
module tb_acc_shift_unit;
  localparam int W = 16;

  typedef struct packed {
    logic [3:0]   op;
    logic [W-1:0] bus;
    logic         hl;
    logic [W-1:0] acc;
    logic [W-1:0] hlp;
    logic         z;
    logic         n;
    logic         c;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{4'd2,  16'h8001, 1'b0, 16'h8001, 16'h0000, 1'b1, 1'b1, 1'b0},
    '{4'd4,  16'h0000, 1'b0, 16'h0002, 16'h0000, 1'b0, 1'b0, 1'b1},
    '{4'd0,  16'h00F1, 1'b1, 16'h0002, 16'h00F1, 1'b0, 1'b0, 1'b1},
    '{4'd6,  16'h0000, 1'b0, 16'h0001, 16'h00F1, 1'b0, 1'b0, 1'b0},
    '{4'd5,  16'h0000, 1'b0, 16'h0000, 16'h00F1, 1'b1, 1'b0, 1'b1},
    '{4'd3,  16'h7FFE, 1'b0, 16'h8001, 16'h00F1, 1'b0, 1'b1, 1'b0},
    '{4'd6,  16'hC000, 1'b0, 16'hC000, 16'h00F1, 1'b1, 1'b1, 1'b1},
    '{4'd7,  16'h0000, 1'b0, 16'h8001, 16'h00F1, 1'b0, 1'b1, 1'b1},
    '{4'd9,  16'h0000, 1'b0, 16'hC000, 16'h8078, 1'b0, 1'b1, 1'b1},
    '{4'd8,  16'h8001, 1'b1, 16'h8001, 16'h00F0, 1'b1, 1'b1, 1'b1},
    '{4'd1,  16'h0000, 1'b0, 16'h0000, 16'h00F0, 1'b1, 1'b0, 1'b0},
    '{4'd12, 16'hFFFF, 1'b0, 16'h0000, 16'h00F0, 1'b1, 1'b0, 1'b0},
    '{4'd2,  16'hFFFF, 1'b1, 16'hFFFF, 16'hFFFF, 1'b1, 1'b1, 1'b0},
    '{4'd9,  16'h0000, 1'b0, 16'hFFFF, 16'hFFFF, 1'b0, 1'b1, 1'b1}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [3:0]   op_code = 4'd0;
  logic [W-1:0] bus_in = '0;
  logic         hr_load = 1'b0;
  logic [W-1:0] acc_q;
  logic [W-1:0] hlp_q;
  logic         flag_z;
  logic         flag_n;
  logic         flag_c;
  logic         bus_busy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  acc_shift_unit #(.W(W)) dut (
    .clk      (clk),
    .rst      (rst),
    .op_code  (op_code),
    .bus_in   (bus_in),
    .hr_load  (hr_load),
    .acc_q    (acc_q),
    .hlp_q    (hlp_q),
    .flag_z   (flag_z),
    .flag_n   (flag_n),
    .flag_c   (flag_c),
    .bus_busy (bus_busy)
  );

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd0:       return "R2";
      4'd1:       return "R3";
      4'd2, 4'd3: return "R4";
      4'd4:       return "R5";
      4'd5:       return "R6";
      4'd6:       return "R7";
      4'd7:       return "R8";
      4'd8:       return "R9";
      4'd9:       return "R10";
      default:    return "R2";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_state(input string req, input logic [W-1:0] ea, input logic [W-1:0] eh,
                             input logic ez, input logic en, input logic ec);
    check(req, "acc", acc_q, ea);
    check(req, "hlp", hlp_q, eh);
    check("R11", "z", {15'd0, flag_z}, {15'd0, ez});
    check("R11", "n", {15'd0, flag_n}, {15'd0, en});
    check(req, "c", {15'd0, flag_c}, {15'd0, ec});
  endtask

  task automatic apply(input logic [3:0] op, input logic [W-1:0] b, input logic hl);
    @(negedge clk);
    op_code = op;
    bus_in  = b;
    hr_load = hl;
    #1;
    check("R13", "bus_busy", {15'd0, bus_busy}, {15'd0, (op >= 4'd4 && op <= 4'd9)});
    @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check_state("R1", 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].op, VEC[i].bus, VEC[i].hl);
      check_state(VEC[i].hl ? "R12" : tag_of(VEC[i].op),
                  VEC[i].acc, VEC[i].hlp, VEC[i].z, VEC[i].n, VEC[i].c);
    end

    // R3: clear with a nonzero bus leaves zero flag low
    apply(4'd1, 16'h1234, 1'b0);
    check_state("R3", 16'h0000, 16'hFFFF, 1'b0, 1'b0, 1'b0);

    // R12: paired right shift overrides helper load
    apply(4'd2, 16'h0003, 1'b1);
    check_state("R12", 16'h0003, 16'h0003, 1'b1, 1'b0, 1'b0);
    apply(4'd9, 16'hAAAA, 1'b1);
    check_state("R12", 16'h0001, 16'h8001, 1'b0, 1'b0, 1'b1);

    // R5: left shift pushes the sign bit out into carry
    apply(4'd2, 16'h4000, 1'b0);
    apply(4'd4, 16'h8000, 1'b0);
    check_state("R5", 16'h8000, 16'h8001, 1'b1, 1'b1, 1'b0);
    apply(4'd4, 16'h0000, 1'b0);
    check_state("R5", 16'h0000, 16'h8001, 1'b1, 1'b0, 1'b1);

    // R6: logical right shift of a negative value fills with zero
    apply(4'd3, 16'h0000, 1'b0);
    apply(4'd5, 16'h7FFF, 1'b0);
    check_state("R6", 16'h7FFF, 16'h8001, 1'b1, 1'b0, 1'b1);

    // R2: unused code 15 with varied bus holds everything
    apply(4'd15, 16'h5555, 1'b0);
    check_state("R2", 16'h7FFF, 16'h8001, 1'b1, 1'b0, 1'b1);

    // R1: reset in mid-run clears everything
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #2;
    check_state("R1", 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule